// File: doc/BRIEF.md
# Staged Buffer Settings Register Block

This block is the register front end of a sampling buffer. Software loads three 12-bit levels through one 16-bit settings location: the output-buffer almost-empty level, the output-buffer almost-full level and the circular-buffer length. Each level arrives as an 8-bit piece and a 4-bit piece, spread over a fixed run of four words. A write to the settings location only stages a word. The word reaches the committed levels when a later access (a read or a write) hits a separate update location. A two-bit phase selects which word the next update commits, and the phase wraps after the fourth word.

The block also holds the two-bit operating mode. Value 00 selects acquisition and 11 selects programming. The other two codes are reserved, and writes of them are refused. The block compares the output-buffer fill count against the committed levels to produce the almost-empty and almost-full flags. A status read returns the mode and both flags. Any access to the reset location puts the whole block back into its power-on state. The surrounding bus decoder supplies single-cycle read and write strobes with a byte offset. Read data is combinational from the same cycle's address.

Top module: `bufcfg_regs`

## Requirements
- R1: After the synchronous reset input, the mode bits read 11 (programming), acq_mode is 0, all three committed levels are 0, and the next update commits word 1.
- R2: A write to offset 0x0C changes no committed level. Committed levels change only in the cycle after an update access or a reset.
- R3: Word 1 is the first update after reset. Its update loads almost-empty bits 7:0 from staged data bits 15:8.
- R4: Word 2 is the second update. Its update loads almost-empty bits 11:8 from staged data bits 11:8.
- R5: Word 3 is the third update. Its update loads almost-full bits 7:0 from data bits 15:8 and circular-length bits 7:0 from data bits 7:0.
- R6: Word 4 is the fourth update. Its update loads almost-full bits 11:8 from data bits 11:8 and circular-length bits 11:8 from data bits 3:0. The update after it commits word 1 again.
- R7: An update is any access to offset 0x0E. A read and a write commit the staged word alike.
- R8: A read or write access to offset 0x10 restores the complete power-on state of R1 by the next cycle. This includes the staged word and the phase.
- R9: A write to offset 0x0A takes data bits 1:0 as the new mode when they are 00 or 11. The values 01 and 10 leave the mode unchanged. acq_mode is 1 exactly when the mode is 00.
- R10: flag_ae is 1 exactly when fill_count is at least the almost-empty level plus one.
- R11: flag_af is 1 exactly when the free room (DEPTH minus fill_count, 0 when the buffer is full or overfull) is at least the almost-full level plus one. DEPTH defaults to 4096.
- R12: A read of offset 0x0A returns mode bit 0 in bit 0, mode bit 1 in bit 1, flag_ae in bit 2, flag_af in bit 3 and zeros above. Reads of any other offset (0x0C included), and cycles without rd_en, return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 5 | Byte offset of the access |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, combinational |
| fill_count | input | 13 | Output-buffer word count, 0 to DEPTH |
| ae_level | output | 12 | Committed almost-empty level |
| af_level | output | 12 | Committed almost-full level |
| circ_len | output | 12 | Committed circular-buffer length |
| mode_bits | output | 2 | Operating mode, 00 acquisition, 11 programming |
| acq_mode | output | 1 | High in acquisition mode |
| flag_ae | output | 1 | Almost-empty flag |
| flag_af | output | 1 | Almost-full flag |

## Verification
A wrong phase does not show at the moment it goes wrong. It shows one update later, when a staged byte lands in the wrong level or in the wrong half of a level. For that reason, every committed level is compared against the model on every clock, across long randomised runs of staging, update, reset and control traffic. A staging register that is not cleared by the reset location stays hidden until an update that follows with no fresh staging write. The random mix produces exactly that sequence. Errors in the flag comparisons appear in the same cycle, but only on the one fill count at each threshold, so the bench drives those exact boundary counts on both sides.

// File: rtl/bufcfg_pkg.sv
package bufcfg_pkg;
    localparam int DATA_W = 16;
    localparam int LVL_W  = 12;
    localparam int ADDR_W = 5;
    localparam int MODE_W = 2;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h0A;
    localparam logic [ADDR_W-1:0] OFS_SET  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_UPD  = 5'h0E;
    localparam logic [ADDR_W-1:0] OFS_RST  = 5'h10;

    localparam logic [MODE_W-1:0] MODE_ACQ  = 2'b00;
    localparam logic [MODE_W-1:0] MODE_PROG = 2'b11;

    typedef enum logic [1:0] {
        PH_AE_LO    = 2'd0,
        PH_AE_HI    = 2'd1,
        PH_AF_CL_LO = 2'd2,
        PH_AF_CL_HI = 2'd3
    } phase_e;

    typedef struct packed {
        logic [LVL_W-1:0] ae;
        logic [LVL_W-1:0] af;
        logic [LVL_W-1:0] clen;
    } cfg_t;

    function automatic logic mode_legal(logic [MODE_W-1:0] v);
        return (v == MODE_ACQ) || (v == MODE_PROG);
    endfunction

    function automatic cfg_t apply_word(cfg_t c, phase_e ph, logic [DATA_W-1:0] w);
        cfg_t n;
        n = c;
        case (ph)
            PH_AE_LO: n.ae[7:0] = w[15:8];
            PH_AE_HI: n.ae[11:8] = w[11:8];
            PH_AF_CL_LO: begin
                n.af[7:0]   = w[15:8];
                n.clen[7:0] = w[7:0];
            end
            default: begin
                n.af[11:8]   = w[11:8];
                n.clen[11:8] = w[3:0];
            end
        endcase
        return n;
    endfunction
endpackage

// File: rtl/bufcfg_stager.sv
module bufcfg_stager
    import bufcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              stage_we,
    input  logic [DATA_W-1:0] stage_data,
    input  logic              commit,
    output cfg_t              cfg_o
);
    logic [DATA_W-1:0] staged;
    phase_e            phase;
    cfg_t              cfg_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            staged <= '0;
            phase  <= PH_AE_LO;
            cfg_q  <= '0;
        end else begin
            if (stage_we) begin
                staged <= stage_data;
            end
            if (commit) begin
                cfg_q <= apply_word(cfg_q, phase, staged);
                phase <= phase_e'(2'(phase + 2'd1));
            end
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/bufcfg_ctrl.sv
module bufcfg_ctrl
    import bufcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              we,
    input  logic [MODE_W-1:0] wdata,
    output logic [MODE_W-1:0] mode_o
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            mode_o <= MODE_PROG;
        end else if (we && mode_legal(wdata)) begin
            mode_o <= wdata;
        end
    end
endmodule

// File: rtl/bufcfg_flags.sv
module bufcfg_flags
    import bufcfg_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int FCW   = $clog2(DEPTH + 1)
) (
    input  logic [FCW-1:0]   fill,
    input  logic [LVL_W-1:0] ae_lvl,
    input  logic [LVL_W-1:0] af_lvl,
    output logic             ae_flag,
    output logic             af_flag
);
    localparam int CW = (FCW > LVL_W) ? FCW : LVL_W;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [CW-1:0] fill_c;
    logic [CW-1:0] room;

    always_comb begin
        fill_c  = CW'(fill);
        room    = (fill_c >= DEPTH_C) ? '0 : (DEPTH_C - fill_c);
        ae_flag = fill_c > CW'(ae_lvl);
        af_flag = room > CW'(af_lvl);
    end
endmodule

// File: rtl/bufcfg_regs.sv
module bufcfg_regs
    import bufcfg_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int FCW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [FCW-1:0]    fill_count,
    output logic [LVL_W-1:0]  ae_level,
    output logic [LVL_W-1:0]  af_level,
    output logic [LVL_W-1:0]  circ_len,
    output logic [MODE_W-1:0] mode_bits,
    output logic              acq_mode,
    output logic              flag_ae,
    output logic              flag_af
);
    logic access;
    logic hit_rst;
    logic hit_upd;
    logic hit_set;
    logic hit_ctrl;
    cfg_t cfg;

    assign access   = wr_en | rd_en;
    assign hit_rst  = access && (addr == OFS_RST);
    assign hit_upd  = access && (addr == OFS_UPD);
    assign hit_set  = wr_en && (addr == OFS_SET);
    assign hit_ctrl = wr_en && (addr == OFS_CTRL);

    bufcfg_stager u_stager (
        .clk        (clk),
        .rst        (rst),
        .clr        (hit_rst),
        .stage_we   (hit_set),
        .stage_data (wr_data),
        .commit     (hit_upd),
        .cfg_o      (cfg)
    );

    bufcfg_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .clr    (hit_rst),
        .we     (hit_ctrl),
        .wdata  (wr_data[MODE_W-1:0]),
        .mode_o (mode_bits)
    );

    bufcfg_flags #(.DEPTH(DEPTH), .FCW(FCW)) u_flags (
        .fill    (fill_count),
        .ae_lvl  (cfg.ae),
        .af_lvl  (cfg.af),
        .ae_flag (flag_ae),
        .af_flag (flag_af)
    );

    assign ae_level = cfg.ae;
    assign af_level = cfg.af;
    assign circ_len = cfg.clen;
    assign acq_mode = (mode_bits == MODE_ACQ);

    always_comb begin
        rd_data = '0;
        if (rd_en && (addr == OFS_CTRL)) begin
            rd_data = {{(DATA_W-4){1'b0}}, flag_af, flag_ae, mode_bits};
        end
    end
endmodule

// File: rtl/bufcfg_regs_chk.sv
module bufcfg_regs_chk
    import bufcfg_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int FCW   = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic [FCW-1:0]    fill_count,
    input logic [LVL_W-1:0]  ae_level,
    input logic [LVL_W-1:0]  af_level,
    input logic [LVL_W-1:0]  circ_len,
    input logic [MODE_W-1:0] mode_bits,
    input logic              acq_mode,
    input logic              flag_ae,
    input logic              flag_af
);
    logic acc_rst;
    logic acc_upd;
    logic bad_ctrl;
    logic [13:0] room;

    assign acc_rst  = (wr_en || rd_en) && (addr == OFS_RST);
    assign acc_upd  = (wr_en || rd_en) && (addr == OFS_UPD);
    assign bad_ctrl = wr_en && (addr == OFS_CTRL) && (wr_data[1] != wr_data[0]);
    assign room     = (32'(fill_count) >= DEPTH) ? 14'd0 : 14'(DEPTH - 32'(fill_count));

    // R2: committed levels move only after an update or a reset
    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(acc_upd) && !$past(acc_rst))
            |-> ($stable(ae_level) && $stable(af_level) && $stable(circ_len)));

    // R8: reset location restores power-on state
    a_r8_soft_reset: assert property (@(posedge clk) disable iff (rst)
        acc_rst |=> (mode_bits == 2'b11 && ae_level == '0 && af_level == '0 && circ_len == '0));

    // R9: reserved codes never appear and are refused
    a_r9_mode_legal: assert property (@(posedge clk) disable iff (rst)
        (mode_bits == 2'b00) || (mode_bits == 2'b11));

    a_r9_bad_ignored: assert property (@(posedge clk) disable iff (rst)
        (bad_ctrl && !acc_rst) |=> $stable(mode_bits));

    // R10: almost-empty flag against fill count
    a_r10_ae_flag: assert property (@(posedge clk) disable iff (rst)
        flag_ae == (14'(fill_count) >= 14'(ae_level) + 14'd1));

    // R11: almost-full flag against free room
    a_r11_af_flag: assert property (@(posedge clk) disable iff (rst)
        flag_af == (room >= 14'(af_level) + 14'd1));

    // R12: no read strobe, no read data
    a_r12_rd_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == '0));
endmodule

bind bufcfg_regs bufcfg_regs_chk #(.DEPTH(DEPTH), .FCW(FCW)) u_chk (.*);

// File: tb/test_bufcfg_regs.sv
module test_bufcfg_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [12:0] fill_count = '0;
    logic [11:0] ae_level, af_level, circ_len;
    logic [1:0]  mode_bits;
    logic        acq_mode, flag_ae, flag_af;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [11:0] m_ae, m_af, m_cl;
    logic [15:0] m_stg;
    int          m_ph;
    logic [1:0]  m_ctrl;

    always #4 clk = ~clk;

    bufcfg_regs i_bufcfg_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .fill_count(fill_count),
        .ae_level(ae_level), .af_level(af_level), .circ_len(circ_len),
        .mode_bits(mode_bits), .acq_mode(acq_mode),
        .flag_ae(flag_ae), .flag_af(flag_af)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic m_reset();
        m_ae = '0; m_af = '0; m_cl = '0; m_stg = '0; m_ph = 0; m_ctrl = 2'b11;
    endtask

    function automatic int exp_ae_f();
        return (int'(fill_count) >= int'(m_ae) + 1) ? 1 : 0;
    endfunction

    function automatic int exp_af_f();
        int room;
        room = (int'(fill_count) >= 4096) ? 0 : 4096 - int'(fill_count);
        return (room >= int'(m_af) + 1) ? 1 : 0;
    endfunction

    function automatic int exp_rd();
        if (!rd_en || addr != 5'h0A) return 0;
        return (exp_af_f() << 3) | (exp_ae_f() << 2) | int'(m_ctrl);
    endfunction

    task automatic cmp_all();
        chk("R3/R4 ae_level", int'(ae_level), int'(m_ae));
        chk("R5/R6 af_level", int'(af_level), int'(m_af));
        chk("R5/R6 circ_len", int'(circ_len), int'(m_cl));
        chk("R9 mode_bits", int'(mode_bits), int'(m_ctrl));
        chk("R9 acq_mode", int'(acq_mode), (m_ctrl == 2'b00) ? 1 : 0);
        chk("R10 flag_ae", int'(flag_ae), exp_ae_f());
        chk("R11 flag_af", int'(flag_af), exp_af_f());
        chk("R12 rd_data", int'(rd_data), exp_rd());
    endtask

    // one access; starts and ends just after a falling edge
    task automatic step(input logic w, input logic r, input logic [4:0] a, input logic [15:0] d);
        wr_en = w; rd_en = r; addr = a; wr_data = d;
        #1;
        cmp_all();
        @(posedge clk);
        if (rst) m_reset();
        else if ((w || r) && a == 5'h10) m_reset();
        else begin
            if (w && a == 5'h0C) m_stg = d;
            if ((w || r) && a == 5'h0E) begin
                case (m_ph)
                    0: m_ae[7:0] = m_stg[15:8];
                    1: m_ae[11:8] = m_stg[11:8];
                    2: begin m_af[7:0] = m_stg[15:8]; m_cl[7:0] = m_stg[7:0]; end
                    default: begin m_af[11:8] = m_stg[11:8]; m_cl[11:8] = m_stg[3:0]; end
                endcase
                m_ph = (m_ph + 1) % 4;
            end
            if (w && a == 5'h0A && (d[1:0] == 2'b00 || d[1:0] == 2'b11)) m_ctrl = d[1:0];
        end
        @(negedge clk);
        wr_en = 0; rd_en = 0; addr = '0; wr_data = '0;
        #1;
        cmp_all();
    endtask

    task automatic prog(input logic [15:0] d, input logic upd_by_read);
        step(1, 0, 5'h0C, d);
        step(!upd_by_read, upd_by_read, 5'h0E, 16'h0);
    endtask

    initial begin
        #1_600_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        m_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk("R1 mode after reset", int'(mode_bits), 3);
        chk("R1 acq_mode after reset", int'(acq_mode), 0);
        chk("R1 ae_level after reset", int'(ae_level), 0);
        chk("R1 circ_len after reset", int'(circ_len), 0);

        // R2 staging alone commits nothing
        step(1, 0, 5'h0C, 16'hAB00);
        chk("R2 staged only", int'(ae_level), 0);
        step(1, 0, 5'h0E, 16'h0);
        chk("R3 word1", int'(ae_level), 12'h0AB);
        prog(16'h0500, 1);
        chk("R4 word2 via read R7", int'(ae_level), 12'h5AB);
        prog(16'hCD34, 0);
        chk("R5 af low", int'(af_level), 12'h0CD);
        chk("R5 clen low", int'(circ_len), 12'h034);
        prog(16'h0E09, 0);
        chk("R6 af", int'(af_level), 12'hECD);
        chk("R6 clen", int'(circ_len), 12'h934);
        prog(16'h1100, 1);
        chk("R6 wrap to word1", int'(ae_level), 12'h511);

        // R9 control writes
        step(1, 0, 5'h0A, 16'h0000);
        chk("R9 acq", int'(mode_bits), 0);
        step(1, 0, 5'h0A, 16'h0001);
        chk("R9 01 ignored", int'(mode_bits), 0);
        step(1, 0, 5'h0A, 16'h0002);
        chk("R9 10 ignored", int'(mode_bits), 0);
        step(1, 0, 5'h0A, 16'h0003);
        chk("R9 prog", int'(mode_bits), 3);
        step(1, 0, 5'h0A, 16'h0000);

        // R10 / R11 boundaries (ae=0x511=1297, af=0xECD=3789)
        fill_count = 13'd1297; #1; chk("R10 at level", int'(flag_ae), 0);
        fill_count = 13'd1298; #1; chk("R10 level+1", int'(flag_ae), 1);
        fill_count = 13'd306;  #1; chk("R11 room 3790", int'(flag_af), 1);
        fill_count = 13'd307;  #1; chk("R11 room 3789", int'(flag_af), 0);
        fill_count = 13'd4096; #1; chk("R11 full", int'(flag_af), 0);
        fill_count = 13'd1298;
        step(0, 1, 5'h0A, 16'h0);
        rd_en = 1; addr = 5'h0A; #1;
        chk("R12 status read", int'(rd_data), 16'h0004);
        addr = 5'h0C; #1;
        chk("R12 write-only reads 0", int'(rd_data), 0);
        rd_en = 0; addr = '0;

        // R8 soft reset clears phase and staging
        prog(16'h7700, 0);
        step(0, 1, 5'h10, 16'h0);
        chk("R8 mode", int'(mode_bits), 3);
        chk("R8 af", int'(af_level), 0);
        step(1, 0, 5'h0E, 16'h0);
        chk("R8 staging cleared", int'(ae_level), 0);
        step(1, 0, 5'h10, 16'h0);
        prog(16'h4200, 0);
        chk("R8 phase back to word1", int'(ae_level), 12'h042);

        // mixed traffic
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[2:0])
                3'd0, 3'd1: a = 5'h0C;
                3'd2, 3'd3: a = 5'h0E;
                3'd4: a = 5'h0A;
                3'd5: a = (lfsr[9:6] == 0) ? 5'h10 : 5'h0E;
                default: a = {lfsr[7:4], 1'b0};
            endcase
            fill_count = (lfsr[15:3] > 13'd4100) ? 13'd4096 : lfsr[15:3];
            step(lfsr[3], !lfsr[3], a, {lfsr[7:0], lfsr[15:8]});
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule